// File: doc/BRIEF.md
# Photon Arrival Histogram Centroid Estimator

This block collects coarse time-to-digital converter bin codes, each one the delay from an enable edge to a detected photon, into a histogram of saturating counters. Since one coarse bin is about 81 ps wide and the target accuracy is a few picoseconds rms, the block does not report the peak bin. It reports the count-weighted mean bin index of the roughly Gaussian arrival distribution, as a fixed-point number with ten fractional bits.

A run starts with a `start` pulse, which clears all state and latches the number of enable cycles to gather. Each `win_strobe` pulse marks an enable edge and opens a new timing window. Bin codes arriving with `ev_valid` are binned only while a window is open and only when the code falls inside the histogram. All other events in the run are counted as dropped. Once the programmed number of windows has been gathered, a sequential divider forms sum(count × bin) / total. When the run collected nothing, the block flags the result empty and does not divide.

Top module: `tdc_centroid`

## Requirements
- R1: A `start` pulse, in any state, clears the histogram, the running sums and `drop_cnt`, lowers `done` and `empty`, latches `run_len`, and raises `busy` on the next cycle. A start during a run aborts that run, and nothing gathered before it affects the next result.
- R2: During a run, an event with `ev_valid` high, a window open and `ev_code` below NBINS (64) adds one to the bin whose index is `ev_code`.
- R3: After `start` no window is open. The first `win_strobe` opens one, and the run ends at strobe number `run_len`+1, which closes window `run_len`. An event in the same cycle as a strobe is judged against the window state from before that strobe.
- R4: During a run, a valid event whose code is NBINS or above, or that arrives while no window is open, increments `drop_cnt`, which saturates at its maximum. Valid events outside a run are ignored and leave `drop_cnt` unchanged.
- R5: `centroid` is floor(sum(count × bin) × 1024 / sum(count)) in unsigned Q6.10. Bits [15:10] hold the whole bin index and bits [9:0] the fraction.
- R6: A bin counter stops at 2^CNT_W−1. Further events into that bin are neither added to the centroid sums nor counted as dropped.
- R7: If no event was binned when the run ends, the block raises `empty` and `done` together and leaves `centroid` at 0.
- R8: `done`, `empty` and `centroid` hold their values until the next `start`.
- R9: `busy` is high from the cycle after `start` until the result is ready. It stays high through the division after the final strobe, and `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear state and begin a run |
| run_len | input | RUN_W | Number of enable windows to gather, latched at start |
| win_strobe | input | 1 | Enable-edge strobe, opens a new window |
| ev_valid | input | 1 | Qualifies ev_code |
| ev_code | input | CODE_W | Coarse bin code of a photon event |
| busy | output | 1 | Run or division in progress |
| done | output | 1 | Result ready |
| empty | output | 1 | Run ended with no binned events |
| centroid | output | IDX_W+FRAC_W | Weighted mean bin, Q6.10 |
| drop_cnt | output | DROP_W | Events dropped in this run |

## Verification
The hardest case to reach from the ports is a bin counter hitting saturation, because the default counters would need billions of events. The bench therefore builds the design with four-bit counters and sends twenty events into a single bin. The expected centroid then excludes the excess, and the drop count stays unchanged. The window edges are the other subtle case. The bench puts an event in the same cycle as the first strobe, where it must be dropped, and in the same cycle as the final strobe, where it must be binned.

// File: rtl/tdc_centroid.sv
module tdc_centroid #(
  parameter int NBINS  = 64,
  parameter int CODE_W = 8,
  parameter int CNT_W  = 32,
  parameter int FRAC_W = 10,
  parameter int RUN_W  = 32,
  parameter int DROP_W = 32,
  localparam int IDX_W = $clog2(NBINS),
  localparam int QW    = IDX_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RUN_W-1:0]  run_len,
  input  logic              win_strobe,
  input  logic              ev_valid,
  input  logic [CODE_W-1:0] ev_code,
  output logic              busy,
  output logic              done,
  output logic              empty,
  output logic [QW-1:0]     centroid,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam int TOT_W  = CNT_W + IDX_W;
  localparam int WS_W   = TOT_W + IDX_W;
  localparam int STEP_W = $clog2(QW);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_END, S_DIV} st_t;

  st_t               st;
  logic [CNT_W-1:0]  hist [NBINS];
  logic [RUN_W-1:0]  len_q, scnt;
  logic              win_open;
  logic [TOT_W-1:0]  total, rem;
  logic [WS_W-1:0]   wsum;
  logic [QW-1:0]     dlo, quo;
  logic [STEP_W-1:0] step;
  logic [TOT_W:0]    trial, diff;
  logic              ge;

  wire [IDX_W-1:0] bin      = ev_code[IDX_W-1:0];
  wire             in_range = ev_code < CODE_W'(NBINS);
  wire             running  = (st == S_RUN) && !start;
  wire             accept   = running && ev_valid && win_open && in_range;
  wire             drop_ev  = running && ev_valid && !(win_open && in_range);
  wire             full     = hist[bin] == '1;

  assign busy  = st != S_IDLE;
  assign trial = {rem, dlo[QW-1]};
  assign diff  = trial - {1'b0, total};
  assign ge    = !diff[TOT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBINS; i++) hist[i] <= '0;
    end else if (start) begin
      for (int i = 0; i < NBINS; i++) hist[i] <= '0;
    end else if (accept && !full) begin
      hist[bin] <= hist[bin] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; len_q <= '0; scnt <= '0; win_open <= 1'b0;
      total <= '0; wsum <= '0; drop_cnt <= '0;
      done <= 1'b0; empty <= 1'b0; centroid <= '0;
      rem <= '0; dlo <= '0; quo <= '0; step <= '0;
    end else if (start) begin
      st <= S_RUN; len_q <= run_len; scnt <= '0; win_open <= 1'b0;
      total <= '0; wsum <= '0; drop_cnt <= '0;
      done <= 1'b0; empty <= 1'b0; centroid <= '0;
    end else begin
      case (st)
        S_RUN: begin
          if (accept && !full) begin
            total <= total + 1'b1;
            wsum  <= wsum + WS_W'(bin);
          end
          if (drop_ev && drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
          if (win_strobe) begin
            if (scnt == len_q) begin
              win_open <= 1'b0;
              st       <= S_END;
            end else begin
              scnt     <= scnt + 1'b1;
              win_open <= 1'b1;
            end
          end
        end
        S_END: begin
          if (total == '0) begin
            empty <= 1'b1;
            done  <= 1'b1;
            st    <= S_IDLE;
          end else begin
            rem  <= wsum[WS_W-1:IDX_W];
            dlo  <= {wsum[IDX_W-1:0], {FRAC_W{1'b0}}};
            quo  <= '0;
            step <= STEP_W'(QW - 1);
            st   <= S_DIV;
          end
        end
        S_DIV: begin
          rem <= ge ? diff[TOT_W-1:0] : trial[TOT_W-1:0];
          dlo <= dlo << 1;
          quo <= {quo[QW-2:0], ge};
          if (step == '0) begin
            centroid <= {quo[QW-2:0], ge};
            done     <= 1'b1;
            st       <= S_IDLE;
          end else begin
            step <= step - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module tdc_centroid_chk #(
  parameter int QW     = 16,
  parameter int DROP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              empty,
  input logic [QW-1:0]     centroid,
  input logic [DROP_W-1:0] drop_cnt
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !done && !empty && drop_cnt == '0); // R1
  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> done && centroid == '0); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(centroid) && $stable(empty)); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(drop_cnt)); // R4
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start |=> drop_cnt == $past(drop_cnt) || drop_cnt == $past(drop_cnt) + 1'b1); // R4
endmodule

bind tdc_centroid tdc_centroid_chk #(.QW(QW), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .empty(empty), .centroid(centroid), .drop_cnt(drop_cnt)
);

// File: tb/tdc_centroid_tb.sv
module tdc_centroid_tb;
  localparam int CNT_W = 4;
  localparam int NB    = 64;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, win_strobe = 1'b0, ev_valid = 1'b0;
  logic [31:0] run_len = '0;
  logic [7:0]  ev_code = '0;
  logic        busy, done, empty;
  logic [15:0] centroid;
  logic [31:0] drop_cnt;

  tdc_centroid #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .run_len(run_len),
    .win_strobe(win_strobe), .ev_valid(ev_valid), .ev_code(ev_code),
    .busy(busy), .done(done), .empty(empty), .centroid(centroid), .drop_cnt(drop_cnt)
  );

  always #2 clk = ~clk;

  typedef struct { int c; bit e; int d; string tag; } exp_t;
  exp_t exq[$];

  int checks = 0, errors = 0;
  bit finished = 0;
  int mh[NB];
  longint mtot, mws;
  int mdrop, scnt, mlen;
  bit mwin, mrun;
  string cur_tag = "R5";

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic push_exp();
    exp_t x;
    x.e = (mtot == 0);
    x.c = x.e ? 0 : int'((mws * 1024) / mtot);
    x.d = mdrop;
    x.tag = cur_tag;
    exq.push_back(x);
  endtask

  task automatic cyc(bit s, int len, bit stb, bit v, int code);
    start = s; run_len = 32'(len); win_strobe = stb; ev_valid = v; ev_code = 8'(code);
    if (s) begin
      for (int i = 0; i < NB; i++) mh[i] = 0;
      mtot = 0; mws = 0; mdrop = 0; scnt = 0; mlen = len; mwin = 0; mrun = 1;
    end else if (mrun) begin
      if (v) begin
        if (code >= NB || !mwin) mdrop++;
        else if (mh[code] < (1 << CNT_W) - 1) begin
          mh[code]++; mtot++; mws += code;
        end
      end
      if (stb) begin
        if (scnt == mlen) begin mrun = 0; mwin = 0; push_exp(); end
        else begin scnt++; mwin = 1; end
      end
    end
    @(negedge clk);
    start = 0; win_strobe = 0; ev_valid = 0;
  endtask

  task automatic start_run(int len); cyc(1, len, 0, 0, 0); endtask
  task automatic ev(int code); cyc(0, 0, 0, 1, code); endtask
  task automatic stb(); cyc(0, 0, 1, 0, 0); endtask

  task automatic finish_run();
    while (mrun) stb();
    chk("R9 busy during division", busy, 1);
    chk("R9 done low during division", done, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  bit done_d = 0;
  always @(negedge clk) begin
    if (rst_n && done && !done_d) begin
      if (exq.size() == 0) chk("R8 unexpected result", 1, 0);
      else begin
        exp_t x;
        x = exq.pop_front();
        chk({x.tag, " centroid"}, centroid, x.c);
        chk("R7 empty flag", empty, x.e);
        chk("R4 drop count", drop_cnt, x.d);
        chk("R9 busy low at done", busy, 0);
      end
    end
    done_d = done;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    summary();
  end

  initial begin
    int hold_c, hold_d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset empty", empty, 0);
    chk("R1 reset drop", drop_cnt, 0);
    chk("R5 reset centroid", centroid, 0);

    // R2 R4 basic run with drops: early event, out-of-range code
    cur_tag = "R2";
    start_run(4);
    chk("R1 busy after start", busy, 1);
    ev(12);
    stb(); ev(10); ev(10); ev(70); stb(); ev(11); ev(64);
    finish_run();

    // R5 single top bin
    cur_tag = "R5";
    start_run(2);
    stb(); ev(63); ev(63); ev(63);
    finish_run();

    // R7 empty runs, including run_len 0
    cur_tag = "R7";
    start_run(2);
    ev(5);
    finish_run();
    start_run(0);
    finish_run();

    // R6 saturation at 15 with CNT_W=4
    cur_tag = "R6";
    start_run(1);
    stb();
    for (int k = 0; k < 20; k++) ev(5);
    ev(6);
    finish_run();

    // R1 abort mid-run, restart
    cur_tag = "R1";
    start_run(3);
    stb(); ev(40); ev(41); ev(99);
    start_run(1);
    stb(); ev(2); ev(3);
    finish_run();

    // R3 events coincident with first and final strobes
    cur_tag = "R3";
    start_run(2);
    cyc(0, 0, 1, 1, 20);
    ev(30); stb();
    cyc(0, 0, 1, 1, 50);
    finish_run();

    // R5 gaussian-like spread
    cur_tag = "R5";
    start_run(3);
    stb();
    for (int b = 22; b <= 38; b++) begin
      int d = (b > 30) ? b - 30 : 30 - b;
      for (int k = 0; k < 15 - 2 * d && k < 15; k++) ev(b);
    end
    stb(); ev(31); ev(33);
    finish_run();

    // R4 R8 idle events ignored, result held
    hold_c = centroid; hold_d = drop_cnt;
    ev(3); ev(99); stb(); ev(7);
    repeat (3) @(negedge clk);
    chk("R4 idle drop unchanged", drop_cnt, hold_d);
    chk("R8 centroid held", centroid, hold_c);
    chk("R8 done held", done, 1);

    chk("R8 no pending results", exq.size(), 0);
    summary();
  end
endmodule